// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 32,768 bytes. The host side uses a request/ready handshake: when `reqReady` is high, a cycle with `reqValid` high hands over a 15-bit address, a direction flag and, for writes, a data byte. The block then produces the active-low chip-enable, output-enable and write-enable waveforms itself. Each phase lasts a number of system-clock cycles set by a parameter.

The shared data bus is split into an outgoing byte, a drive enable for the pad tri-state and an incoming byte. A read holds chip-enable and output-enable low for the access phase. It samples the bus on the edge that ends that phase, pulses `rdValid` for one cycle, and then leaves a float gap before the bus can be reused. A write drops chip-enable and write-enable first. It waits a turnaround gap with the bus undriven, drives the data for the write pulse, and raises write-enable while the data is still driven, so that the data hold is measured from the edge that ends the write.

The defaults assume a 200 MHz clock and the 10 ns speed grade. They give a 15 ns access phase, a 10 ns float gap, a 15 ns write pulse and 5 ns of data hold.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever idle, `memCeN`, `memOeN` and `memWeN` are 1, `memDoutEn` is 0, `reqReady` is 1 and `rdValid` is 0.
- R2: A request is taken only on a clock edge where `reqReady` and `reqValid` are both 1. `reqReady` stays 0 from the next cycle until the transaction ends. `memAddr` holds the taken address for as long as `memCeN` is 0, whatever `reqAddr` does meanwhile.
- R3: A read (`reqWrite`=0) first spends RD_ACC_CYC cycles with `memCeN`=0, `memOeN`=0, `memWeN`=1 and `memDoutEn`=0.
- R4: The byte on `memDin` in the last access cycle appears on `rdData` in the next cycle. `rdValid` is 1 for exactly that one cycle.
- R5: After the access phase, a read spends TURN_CYC cycles with `memCeN`=1, `memOeN`=1 and `memDoutEn`=0 before `reqReady` returns to 1.
- R6: A write (`reqWrite`=1) first spends TURN_CYC cycles with `memCeN`=0, `memWeN`=0, `memOeN`=1 and `memDoutEn`=0.
- R7: A write then spends WR_PULSE_CYC cycles with `memCeN`=0, `memWeN`=0, `memOeN`=1, `memDoutEn`=1 and `memDout` equal to the taken data byte.
- R8: A write then spends WR_HOLD_CYC cycles with `memWeN`=1 and `memCeN`=0, still driving the same byte. The write therefore ends on the rising edge of write-enable with the data stable, and the location afterwards holds that byte.
- R9: `memDoutEn` and an asserted `memOeN` (0) never occur in the same cycle. Output-enable never falls in a cycle that directly follows a cycle in which the bus was driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request strobe |
| reqReady | output | 1 | High when idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Host byte address |
| reqWdata | input | 8 | Host write byte |
| rdValid | output | 1 | One-cycle pulse marking `rdData` valid |
| rdData | output | 8 | Byte returned by a read |
| memAddr | output | 15 | RAM address lines |
| memCeN | output | 1 | RAM chip enable, active low |
| memOeN | output | 1 | RAM output enable, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memDout | output | 8 | Byte toward the RAM data pads |
| memDoutEn | output | 1 | Pad tri-state enable for `memDout` |
| memDin | input | 8 | Byte from the RAM data pads |

## Verification
The bench targets the turnaround points where a wrong design would fight the RAM on the bus. The first is a write right after a read. A design that drove data too early would overlap the RAM's output float, and the contention monitor would catch it. The second is a read right after a write. A design that dropped output-enable while still driving would trip the same monitor. Writes to the lowest and highest addresses, and an overwrite followed by a read-back, expose a data hold that ends with or before write-enable, because the behavioural RAM then stores an undriven byte. Changing `reqAddr` in the middle of a transaction exposes an address that was not latched.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ACC, ST_RD_FLOAT, ST_WR_TURN, ST_WR_DATA, ST_WR_HOLD
  } phase_t;

  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic drvEn;
    logic take;
    logic capture;
  } strobe_t;
endpackage

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int RD_ACC_CYC   = 3,
  parameter int TURN_CYC     = 2,
  parameter int WR_PULSE_CYC = 3,
  parameter int WR_HOLD_CYC  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);
  localparam int MAX_A = (RD_ACC_CYC > TURN_CYC) ? RD_ACC_CYC : TURN_CYC;
  localparam int MAX_B = (WR_PULSE_CYC > WR_HOLD_CYC) ? WR_PULSE_CYC : WR_HOLD_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  phase_t            phase, phaseNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  logic              cntDone;

  assign cntDone = (cnt == '0);

  always_comb begin
    phaseNxt = phase;
    cntNxt   = cntDone ? cnt : cnt - 1'b1;
    unique case (phase)
      ST_IDLE: if (reqValid) begin
        phaseNxt = reqWrite ? ST_WR_TURN : ST_RD_ACC;
        cntNxt   = reqWrite ? CNT_W'(TURN_CYC - 1) : CNT_W'(RD_ACC_CYC - 1);
      end
      ST_RD_ACC: if (cntDone) begin
        phaseNxt = ST_RD_FLOAT;
        cntNxt   = CNT_W'(TURN_CYC - 1);
      end
      ST_RD_FLOAT: if (cntDone) phaseNxt = ST_IDLE;
      ST_WR_TURN: if (cntDone) begin
        phaseNxt = ST_WR_DATA;
        cntNxt   = CNT_W'(WR_PULSE_CYC - 1);
      end
      ST_WR_DATA: if (cntDone) begin
        phaseNxt = ST_WR_HOLD;
        cntNxt   = CNT_W'(WR_HOLD_CYC - 1);
      end
      ST_WR_HOLD: if (cntDone) phaseNxt = ST_IDLE;
      default: phaseNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phaseNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    strb.ceN     = !(phase inside {ST_RD_ACC, ST_WR_TURN, ST_WR_DATA, ST_WR_HOLD});
    strb.oeN     = (phase != ST_RD_ACC);
    strb.weN     = !(phase inside {ST_WR_TURN, ST_WR_DATA});
    strb.drvEn   = (phase inside {ST_WR_DATA, ST_WR_HOLD});
    strb.take    = (phase == ST_IDLE) && reqValid;
    strb.capture = (phase == ST_RD_ACC) && cntDone;
  end

  assign reqReady = (phase == ST_IDLE);

  // R9: the pads are never driven while the RAM output buffers are enabled
  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.drvEn && !strb.oeN));

  // R9: output enable falls only after an undriven cycle
  p_oe_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.oeN) |-> !$past(strb.drvEn));

  // R2: a taken request makes the block busy on the next cycle
  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> !reqReady);

  // R8: write enable rises while chip enable is still low
  p_we_ends_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.weN) |-> !strb.ceN && strb.drvEn);
endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strb.take) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdData <= memDin;
      rdValid <= strb.capture;
    end
  end

  assign memAddr   = addrQ;
  assign memDout   = wdataQ;
  assign memDoutEn = strb.drvEn;
  assign memCeN    = strb.ceN;
  assign memOeN    = strb.oeN;
  assign memWeN    = strb.weN;

  // R2: the address lines stay put while the chip is selected
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R8: the driven byte does not move across the end of the write
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> $stable(memDout));

  // R4: read-valid is a single-cycle pulse
  p_rdvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int RD_ACC_CYC   = 3,
  parameter int TURN_CYC     = 2,
  parameter int WR_PULSE_CYC = 3,
  parameter int WR_HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);
  strobe_t strb;

  asram_ctl #(
    .RD_ACC_CYC(RD_ACC_CYC), .TURN_CYC(TURN_CYC),
    .WR_PULSE_CYC(WR_PULSE_CYC), .WR_HOLD_CYC(WR_HOLD_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strb(strb)
  );

  asram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr), .memCeN(memCeN),
    .memOeN(memOeN), .memWeN(memWeN), .memDout(memDout), .memDoutEn(memDoutEn),
    .memDin(memDin)
  );
endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
  localparam int RD  = 3;
  localparam int TRN = 2;
  localparam int PW  = 3;
  localparam int HLD = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic reqReady, rdValid, memCeN, memOeN, memWeN, memDoutEn;
  logic [7:0]  rdData, memDout, memDin;
  logic [14:0] memAddr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  asram_ctrl #(.RD_ACC_CYC(RD), .TURN_CYC(TRN), .WR_PULSE_CYC(PW), .WR_HOLD_CYC(HLD)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin)
  );

  // behavioural RAM
  logic [7:0] ram [int];
  always_comb begin
    if (!memCeN && !memOeN && memWeN)
      memDin = ram.exists(int'(memAddr)) ? ram[int'(memAddr)] : 8'hxx;
    else
      memDin = 8'hzz;
  end
  always @(posedge memWeN) if (!memCeN) ram[int'(memAddr)] = memDoutEn ? memDout : 8'hxx;

  typedef struct {
    string      tag;
    logic       ce, oe, we, de, rdy, rv;
    logic [14:0] addr;
    logic [7:0]  data;
  } exp_t;
  exp_t expQ[$];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // cycle-by-cycle comparison against the model queue
  always @(negedge clk) if (rstN) begin
    exp_t e;
    if (expQ.size() != 0) e = expQ.pop_front();
    else begin
      e.tag = "R1"; e.ce = 1; e.oe = 1; e.we = 1; e.de = 0; e.rdy = 1; e.rv = 0;
      e.addr = '0; e.data = '0;
    end
    chk(e.tag, "ceN/oeN/weN/doutEn", {memCeN, memOeN, memWeN, memDoutEn},
        {e.ce, e.oe, e.we, e.de});
    chk("R2", "reqReady", reqReady, e.rdy);
    chk("R4", "rdValid", rdValid, e.rv);
    if (!e.ce) chk("R2", "memAddr", memAddr, e.addr);
    if (e.de) chk("R7", "memDout", memDout, e.data);
    if (e.rv) chk("R4", "rdData", rdData, e.data);
    chk("R9", "no contention", (memDoutEn && !memOeN), 1'b0);
  end

  function automatic exp_t mk(string t, logic ce, logic oe, logic we, logic de, logic rv,
                              logic [14:0] a, logic [7:0] d);
    exp_t e;
    e.tag = t; e.ce = ce; e.oe = oe; e.we = we; e.de = de; e.rdy = 0; e.rv = rv;
    e.addr = a; e.data = d;
    return e;
  endfunction

  task automatic xact(bit wr, logic [14:0] a, logic [7:0] d, logic [7:0] rdExp);
    @(negedge clk); #1;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    if (wr) begin
      for (int i = 0; i < TRN; i++) expQ.push_back(mk("R6", 0, 1, 0, 0, 0, a, d));
      for (int i = 0; i < PW;  i++) expQ.push_back(mk("R7", 0, 1, 0, 1, 0, a, d));
      for (int i = 0; i < HLD; i++) expQ.push_back(mk("R8", 0, 1, 1, 1, 0, a, d));
    end else begin
      for (int i = 0; i < RD;  i++) expQ.push_back(mk("R3", 0, 0, 1, 0, 0, a, rdExp));
      for (int i = 0; i < TRN; i++) expQ.push_back(mk("R5", 1, 1, 1, 0, i == 0, a, rdExp));
    end
    @(posedge clk); #1;
    reqValid = 0;
    reqAddr  = ~a;       // R2: a moving address after acceptance must not reach the pins
    reqWdata = ~d;
    while (expQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1", "reset pins", {memCeN, memOeN, memWeN, memDoutEn, reqReady, rdValid}, 6'b111010);
    rstN = 1;
    repeat (2) @(negedge clk);
    xact(1, 15'h0000, 8'hA5, 8'h00);
    xact(1, 15'h7FFF, 8'h5A, 8'h00);
    xact(0, 15'h0000, 8'h00, 8'hA5);   // R4 read back lowest address
    xact(0, 15'h7FFF, 8'h00, 8'h5A);   // R4 read back highest address
    xact(1, 15'h1234, 8'h00, 8'h00);
    xact(1, 15'h1234, 8'hFF, 8'h00);   // R8 overwrite
    xact(0, 15'h1234, 8'h00, 8'hFF);
    xact(1, 15'h2AAA, 8'h3C, 8'h00);   // write right after read
    xact(0, 15'h2AAA, 8'h00, 8'h3C);   // read right after write
    xact(0, 15'h0000, 8'h00, 8'hA5);   // read after read
    repeat (4) @(negedge clk);
    report();
  end
endmodule